// File: doc/BRIEF.md
# Write-Only Two-Wire Bus Slave Receiver

This block is the receive front end of a two-wire bus slave that only accepts write transfers. It runs entirely in the system clock domain. The SCL and SDA lines are synchronised and then filtered, so that a level change is accepted only after a configurable number of consecutive agreeing samples. From the filtered lines it recognises bus start and stop conditions and the rising and falling edges of SCL. It shifts bytes in most significant bit first and compares the first byte of each transfer against the slave's own address.

The slave's 7-bit address is a fixed 5-bit prefix followed by two strap pins. When the address matches and the transfer is a write, the slave acknowledges, raises `selected` and passes every later data byte to a downstream parser with a one-cycle `byte_valid` strobe. Start and stop conditions are reported as one-cycle strobes at any bit position. A parser can therefore drop a partly built command when a transfer is cut short. The acknowledge is an open-drain pull request: the pad logic outside the block drives SDA low while `sda_pull` is high.

Top module: `twr_slave_rx`

## Requirements
- R1: After reset, `sda_pull`, `selected`, `byte_valid`, `start_seen` and `stop_seen` are all 0.
- R2: An address byte equal to {0,1,0,1,0,`strap_hi`,`strap_lo`} in bits 7..1, with bit 0 equal to 0 (write), raises `selected` and makes the block pull SDA low during the ninth SCL high phase of that byte.
- R3: An address byte with a different 7-bit address, or with bit 0 equal to 1, leaves `selected` at 0 and gets no acknowledge. The data bytes that follow produce no `byte_valid`.
- R4: While the block is selected, each complete data byte is received MSB first. It produces one single-cycle `byte_valid` pulse with the byte on `rx_byte`, and it is acknowledged in its ninth clock.
- R5: `start_seen` pulses for one cycle on every START and repeated START (SDA falling while SCL is high). `stop_seen` pulses for one cycle on every STOP (SDA rising while SCL is high). The two never pulse together.
- R6: A STOP or START that arrives partway through a byte discards the partial byte (no `byte_valid`) and releases SDA.
- R7: `selected` falls in the cycle after `stop_seen`. A repeated START followed by a non-matching address clears `selected`.
- R8: A pulse on SCL or SDA shorter than FILT_LEN system clocks has no effect: no condition is detected and no bit is counted.
- R9: SDA is never pulled outside the acknowledge slot of a selected transfer. In particular, `sda_pull` is 0 during the high phase of every data and address bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw SCL level from the pad |
| sda_in | input | 1 | Raw SDA level from the pad (wired-AND bus value) |
| strap_hi | input | 1 | Upper strap bit, address bit 1 |
| strap_lo | input | 1 | Lower strap bit, address bit 0 |
| sda_pull | output | 1 | High when SDA is to be driven low (open-drain acknowledge) |
| rx_byte | output | 8 | Last data byte received |
| byte_valid | output | 1 | One-cycle strobe: `rx_byte` holds a new data byte |
| start_seen | output | 1 | One-cycle strobe on START or repeated START |
| stop_seen | output | 1 | One-cycle strobe on STOP |
| selected | output | 1 | Slave is addressed for the current write transfer |

## Verification
The assertions assume that the bus obeys the protocol at filtered speed. SCL phases last much longer than the filter plus synchroniser delay, so two SCL edges never reach the event logic in adjacent cycles, and SDA changes only while SCL is low, apart from deliberate start and stop conditions. The bench models the bus as a wired-AND of the master's SDA and the slave's pull. It holds every SCL phase for 24 system clocks and changes SDA only in the middle of a low phase. Glitches are injected only where they are meant to be rejected, and they are always one clock shorter than the filter length.

// File: rtl/twr_pkg.sv
package twr_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 4;
  localparam int PREFIX_W = 5;

  typedef struct packed {
    logic scl_rise;
    logic scl_fall;
    logic start;
    logic stop;
    logic sda_lvl;
  } twr_ev_t;
endpackage

// File: rtl/twr_line_filter.sv
module twr_line_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic filt
);
  logic [1:0]          sync_q;
  logic [FILT_LEN-1:0] hist_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      hist_q <= '1;
      filt   <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], raw};
      hist_q <= {hist_q[FILT_LEN-2:0], sync_q[1]};
      if (&hist_q)       filt <= 1'b1;
      else if (~|hist_q) filt <= 1'b0;
    end
  end

  // R8: the output only moves toward a level the synchroniser has held
  a_r8_change_agrees: assert property (@(posedge clk) disable iff (rst)
    (filt != $past(filt)) |-> ($past(sync_q[1], 2) == filt));
endmodule

// File: rtl/twr_bus_events.sv
module twr_bus_events
  import twr_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    scl_f,
  input  logic    sda_f,
  output twr_ev_t ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  always_comb begin
    ev.scl_rise = scl_f & ~scl_q;
    ev.scl_fall = ~scl_f & scl_q;
    ev.start    = scl_f & scl_q & sda_q & ~sda_f;
    ev.stop     = scl_f & scl_q & ~sda_q & sda_f;
    ev.sda_lvl  = sda_f;
  end

  // R5: a start and a stop cannot be seen in the same cycle
  a_r5_ev_excl: assert property (@(posedge clk) disable iff (rst)
    !(ev.start && ev.stop));
endmodule

// File: rtl/twr_slave_rx.sv
module twr_slave_rx
  import twr_pkg::*;
#(
  parameter int                FILT_LEN = 4,
  parameter logic [PREFIX_W-1:0] PREFIX = 5'b01010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              strap_hi,
  input  logic              strap_lo,
  output logic              sda_pull,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              byte_valid,
  output logic              start_seen,
  output logic              stop_seen,
  output logic              selected
);
  localparam int NLINES = 2;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ACK_WAIT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W + 1);

  logic [NLINES-1:0] raw_lines, filt_lines;
  twr_ev_t           ev;

  assign raw_lines = {sda_in, scl_in};

  for (genvar i = 0; i < NLINES; i++) begin : g_filt
    twr_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk (clk),
      .rst (rst),
      .raw (raw_lines[i]),
      .filt(filt_lines[i])
    );
  end

  twr_bus_events u_ev (
    .clk  (clk),
    .rst  (rst),
    .scl_f(filt_lines[0]),
    .sda_f(filt_lines[1]),
    .ev   (ev)
  );

  logic              active, in_addr, ack_due;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] shreg, shnext;
  logic              addr_hit;

  assign shnext   = {shreg[BYTE_W-2:0], ev.sda_lvl};
  assign addr_hit = (shnext[BYTE_W-1:1] == {PREFIX, strap_hi, strap_lo}) && !shnext[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      active     <= 1'b0;
      in_addr    <= 1'b0;
      ack_due    <= 1'b0;
      bit_cnt    <= '0;
      shreg      <= '0;
      sda_pull   <= 1'b0;
      rx_byte    <= '0;
      byte_valid <= 1'b0;
      start_seen <= 1'b0;
      stop_seen  <= 1'b0;
      selected   <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      start_seen <= 1'b0;
      stop_seen  <= 1'b0;
      if (stop_seen) selected <= 1'b0;
      if (ev.stop) begin
        active    <= 1'b0;
        bit_cnt   <= '0;
        sda_pull  <= 1'b0;
        stop_seen <= 1'b1;
      end else if (ev.start) begin
        active     <= 1'b1;
        in_addr    <= 1'b1;
        bit_cnt    <= '0;
        sda_pull   <= 1'b0;
        start_seen <= 1'b1;
      end else if (active) begin
        if (ev.scl_rise && bit_cnt < ACK_WAIT) begin
          shreg   <= shnext;
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == LAST_BIT) begin
            if (in_addr) begin
              selected <= addr_hit;
              ack_due  <= addr_hit;
              in_addr  <= 1'b0;
            end else begin
              ack_due <= selected;
              if (selected) begin
                byte_valid <= 1'b1;
                rx_byte    <= shnext;
              end
            end
          end
        end else if (ev.scl_fall && bit_cnt == ACK_WAIT) begin
          sda_pull <= ack_due;
          bit_cnt  <= ACK_SLOT;
        end else if (ev.scl_fall && bit_cnt == ACK_SLOT) begin
          sda_pull <= 1'b0;
          bit_cnt  <= '0;
        end
      end
    end
  end

  // R4: data strobe lasts exactly one cycle
  a_r4_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    byte_valid |=> !byte_valid);
  // R3: no data is passed on unless addressed
  a_r3_valid_needs_sel: assert property (@(posedge clk) disable iff (rst)
    byte_valid |-> selected);
  // R9: the line is only pulled for a selected transfer
  a_r9_pull_needs_sel: assert property (@(posedge clk) disable iff (rst)
    sda_pull |-> selected);
  // R6: any bus condition releases the line
  a_r6_cond_releases: assert property (@(posedge clk) disable iff (rst)
    (start_seen || stop_seen) |-> !sda_pull);
  // R7: stop deselects on the following cycle
  a_r7_stop_deselects: assert property (@(posedge clk) disable iff (rst)
    stop_seen |=> !selected);
  // R5: the two condition strobes never coincide
  a_r5_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    !(start_seen && stop_seen));
endmodule

// File: tb/sim_twr_slave_rx.sv
module sim_twr_slave_rx;
  localparam int CLK_PERIOD = 10;
  localparam int FILT = 4;
  localparam int H = 24;
  localparam int Q = 12;
  localparam int LIMIT = 190000;

  logic clk = 1'b0, rst = 1'b1, m_scl = 1'b1, m_sda = 1'b1;
  logic strap_hi = 1'b1, strap_lo = 1'b0;
  logic sda_pull, byte_valid, start_seen, stop_seen, selected;
  logic [7:0] rx_byte;
  logic sda_bus;
  assign sda_bus = m_sda & ~sda_pull;

  always #(CLK_PERIOD/2) clk = ~clk;

  twr_slave_rx #(.FILT_LEN(FILT)) u0 (
    .clk(clk), .rst(rst), .scl_in(m_scl), .sda_in(sda_bus),
    .strap_hi(strap_hi), .strap_lo(strap_lo), .sda_pull(sda_pull),
    .rx_byte(rx_byte), .byte_valid(byte_valid), .start_seen(start_seen),
    .stop_seen(stop_seen), .selected(selected));

  int checks = 0, fails = 0, nvalid = 0, nstart = 0, nstop = 0;
  logic [7:0] last_byte = '0;
  bit done = 0;

  always @(negedge clk) if (!rst) begin
    if (byte_valid) begin nvalid++; last_byte = rx_byte; end
    if (start_seen) nstart++;
    if (stop_seen)  nstop++;
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic send_bit(bit b);
    tick(Q); m_sda = b; tick(Q); m_scl = 1'b1; tick(H/2);
    check(!sda_pull, "R9 no pull in bit slot", sda_pull, 0);
    tick(H/2); m_scl = 1'b0;
  endtask

  task automatic send_byte(logic [7:0] v, output bit ack);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    tick(Q); m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(H/2);
    ack = sda_pull; tick(H/2); m_scl = 1'b0;
  endtask

  task automatic bus_start();
    tick(Q); m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(H); m_sda = 1'b0; tick(H); m_scl = 1'b0;
  endtask

  task automatic bus_stop();
    tick(Q); m_sda = 1'b0; tick(Q); m_scl = 1'b1; tick(H); m_sda = 1'b1; tick(H);
  endtask

  function automatic logic [7:0] own_addr(bit rw);
    return {5'b01010, strap_hi, strap_lo, rw};
  endfunction

  function automatic bit expect_hit(logic [7:0] a);
    return (a[7:1] == {5'b01010, strap_hi, strap_lo}) && !a[0];
  endfunction

  initial begin
    #(CLK_PERIOD * LIMIT);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    bit ack;
    int v0, s0, p0;
    logic [7:0] a, d;
    tick(5); rst = 1'b0; tick(3);
    // R1 reset state
    check(!sda_pull && !selected && !byte_valid && !start_seen && !stop_seen,
          "R1 reset outputs", {sda_pull, selected, byte_valid}, 0);

    // R2 / R4 / R5 / R7 directed matched write
    s0 = nstart; p0 = nstop; v0 = nvalid;
    bus_start();
    check(nstart == s0 + 1, "R5 start strobe", nstart - s0, 1);
    send_byte(own_addr(1'b0), ack);
    check(ack, "R2 address ack", ack, 1);
    check(selected, "R2 selected", selected, 1);
    send_byte(8'hA5, ack);
    check(ack && last_byte == 8'hA5, "R4 byte A5", last_byte, 8'hA5);
    send_byte(8'h3C, ack);
    check(ack && last_byte == 8'h3C, "R4 byte 3C", last_byte, 8'h3C);
    check(nvalid == v0 + 2, "R4 valid count", nvalid - v0, 2);
    bus_stop();
    check(nstop == p0 + 1, "R5 stop strobe", nstop - p0, 1);
    check(!selected, "R7 deselect after stop", selected, 0);

    // R3 read bit set
    v0 = nvalid;
    bus_start(); send_byte(own_addr(1'b1), ack);
    check(!ack && !selected, "R3 read not acked", {ack, selected}, 0);
    send_byte(8'h77, ack);
    check(!ack && nvalid == v0, "R3 no data when read", nvalid - v0, 0);
    bus_stop();

    // R3 wrong strap
    bus_start(); send_byte({5'b01010, ~strap_hi, strap_lo, 1'b0}, ack);
    check(!ack && !selected, "R3 wrong address", {ack, selected}, 0);
    send_byte(8'h11, ack);
    check(nvalid == v0, "R3 no data wrong addr", nvalid - v0, 0);
    bus_stop();

    // R6 stop mid-byte
    v0 = nvalid;
    bus_start(); send_byte(own_addr(1'b0), ack); send_byte(8'h5A, ack);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    bus_stop();
    check(nvalid == v0 + 1 && last_byte == 8'h5A, "R6 partial dropped on stop", nvalid - v0, 1);
    check(!sda_pull, "R6 released", sda_pull, 0);

    // R6 repeated start mid-byte, R7 mismatched repeat clears selected
    v0 = nvalid; s0 = nstart;
    bus_start(); send_byte(own_addr(1'b0), ack);
    send_bit(1'b0); send_bit(1'b1);
    bus_start();
    check(nstart == s0 + 2 && nvalid == v0, "R6 partial dropped on restart", nvalid - v0, 0);
    check(selected, "R7 held over restart", selected, 1);
    send_byte(8'h20, ack);
    check(!selected && !ack, "R7 restart other address", selected, 0);
    send_byte(8'hEE, ack);
    check(nvalid == v0, "R7 no data after mismatch", nvalid - v0, 0);
    bus_stop();

    // R8 glitches
    s0 = nstart; p0 = nstop;
    tick(H); m_sda = 1'b0; tick(FILT - 1); m_sda = 1'b1; tick(H);
    check(nstart == s0 && nstop == p0, "R8 sda glitch idle", nstart - s0, 0);
    v0 = nvalid;
    bus_start();
    tick(Q); m_scl = 1'b1; tick(FILT - 1); m_scl = 1'b0; tick(Q);
    send_byte(own_addr(1'b0), ack);
    tick(Q); m_scl = 1'b1; tick(FILT - 1); m_scl = 1'b0;
    send_byte(8'hC3, ack);
    check(ack && nvalid == v0 + 1 && last_byte == 8'hC3, "R8 scl glitch ignored", last_byte, 8'hC3);
    bus_stop();

    // random traffic
    void'($urandom(32'h1357));
    for (int t = 0; t < 30; t++) begin
      bit hit; int nb;
      strap_hi = 1'($urandom); strap_lo = 1'($urandom);
      a = ($urandom % 2) ? own_addr(1'($urandom % 4 == 0)) : 8'($urandom);
      hit = expect_hit(a);
      nb = 1 + ($urandom % 3);
      v0 = nvalid;
      bus_start(); send_byte(a, ack);
      check(ack == hit && selected == hit, "R2 R3 random address", ack, hit);
      for (int k = 0; k < nb; k++) begin
        d = 8'($urandom);
        send_byte(d, ack);
        if (hit) check(ack && last_byte == d, "R4 random data", last_byte, d);
      end
      check(nvalid == v0 + (hit ? nb : 0), "R4 random count", nvalid - v0, hit ? nb : 0);
      bus_stop();
      check(!selected && !sda_pull, "R7 random end", selected, 0);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule